// File: doc/BRIEF.md
# Serial EEPROM MAC Address Autoloader

After reset this block reads the station hardware address from a three-wire serial EEPROM (select, shift clock, data toward the part, data back from the part) with no help from software. It first reads word 0 using an 8-bit address. The value found there tells it whether the attached part takes 8-bit or 6-bit word addresses. It then reads three 16-bit words, starting at word 7, and assembles them into a 48-bit address. The serial clock comes from a fixed divider of the system clock. Every half period of the serial clock lasts `HALF_DIV` system clocks, and `HALF_DIV` must be at least 4.

When the load is complete, a done flag rises and the pins are handed over to an 8-bit control register. Software then drives select, clock and data directly, which lets it issue any command, including write and erase. The data returned by the EEPROM is read back in bit 0 of the same register. Before the load completes, writes to the register are discarded.

Top module: `mw_mac_loader`

## Requirements
- R1: While reset is held, `autoload_done` is 0, `mac_addr` is 0, the three EEPROM outputs are 0 and `ctl_rdata[7:1]` is 0.
- R2: During the autoload, every high phase of `ee_sk` lasts exactly `HALF_DIV` clocks and no low phase is shorter than `HALF_DIV` clocks.
- R3: Each autoload access first holds `ee_cs` low and then raises it with `ee_sk` low. It then shifts out, MSB first, a start bit of 1, the read opcode `10` and the word address. The autoload makes exactly four accesses.
- R4: During the autoload, `ee_di` changes only while `ee_sk` is low.
- R5: After the address, each access clocks in exactly 16 data bits, MSB first. Each bit is sampled at the end of a high phase of `ee_sk`. `ee_cs` then drops. Each access therefore has 3 + address-width + 16 rising clock edges.
- R6: Word 0 is read with an 8-bit address. If it equals 0x8129, the following reads use 8-bit addresses; otherwise they use 6-bit addresses.
- R7: `mac_addr[16k+15:16k]` holds the EEPROM word at address 7+k, for k = 0, 1, 2. Address byte n sits at `mac_addr[8n+7:8n]`, so the low byte of each word is the earlier address byte.
- R8: `autoload_done` rises once the third address word is stored and then stays high. After that, `mac_addr` no longer changes.
- R9: Writes to the control register before `autoload_done` is set have no effect: `ctl_rdata[7:1]` reads 0 and the pins stay idle after the load.
- R10: Once the load is done and control bit 7 is 1, `ee_cs`, `ee_sk` and `ee_di` follow control bits 3, 2 and 1. Any command, including write and erase, can be shifted this way.
- R11: Once the load is done and control bit 7 is 0, all three EEPROM outputs are 0, whatever bits 3..1 hold.
- R12: `ctl_rdata[0]` returns `ee_do` through a two-stage synchronizer. `ctl_rdata[7:1]` returns the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value, bit 0 is synchronized EEPROM data |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| mac_addr | output | 48 | Loaded station address, byte n at bits 8n+7..8n |
| autoload_done | output | 1 | Load finished; register owns the pins |

## Verification
The case that matters is a software write to the control register arriving in the same cycle as the autoload's final store, when `autoload_done` rises. The bench issues random register writes, with the enable bit set, throughout every load, so some land on that edge. A write that lands there must be discarded: the bench checks that the register reads back zero and the pins are idle afterwards. The bench also checks the width decision by logging the word addresses seen by an EEPROM model. A signature that differs by a single bit must make an 8-bit part see addresses 28, 32 and 36 instead of 7, 8 and 9.

// File: rtl/mwl_pkg.sv
package mwl_pkg;
    localparam int WORD_W      = 16;
    localparam int ADDR_WIDE   = 8;
    localparam int ADDR_NARROW = 6;
    localparam int OPC_W       = 3;
    localparam int CMD_W       = OPC_W + ADDR_WIDE;
    localparam int BIT_W       = $clog2(WORD_W);
    localparam int MAC_BASE    = 7;
    localparam int MAC_WORDS   = 3;
    localparam int MAC_W       = MAC_WORDS * WORD_W;
    localparam int WIDX_W      = $clog2(MAC_WORDS + 1);

    localparam logic [OPC_W-1:0]  OPC_READ = 3'b110;
    localparam logic [WORD_W-1:0] WIDE_SIG = 16'h8129;

    // control register bit positions
    localparam int CB_DOUT = 0;
    localparam int CB_DIN  = 1;
    localparam int CB_CLK  = 2;
    localparam int CB_SEL  = 3;
    localparam int CB_EN   = 7;

    typedef enum logic [3:0] {
        S_CSLO, S_CSHI, S_CMDL, S_CMDH, S_GAP, S_DATH, S_DATL, S_FIN, S_DONE
    } seq_st_e;

    typedef struct packed {
        seq_st_e           st;
        logic [BIT_W-1:0]  bitn;
        logic [WIDX_W-1:0] widx;
        logic              aw8;
        logic [WORD_W-1:0] sh;
        logic [MAC_W-1:0]  mac;
        logic              done;
        logic              cs;
        logic              sk;
        logic              di;
    } seq_t;

    typedef struct packed {
        logic [7:1] bits;
    } ctl_t;
endpackage

// File: rtl/mw_divider.sv
module mw_divider #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = cnt_q;
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_seq.sv
module mw_seq import mwl_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             do_in,
    output logic             cs,
    output logic             sk,
    output logic             di,
    output logic [MAC_W-1:0] mac,
    output logic             done
);
    seq_t q, n;
    logic             use_wide;
    logic [7:0]       word_addr;
    logic [CMD_W-1:0] cmd;

    always_comb begin
        n         = q;
        use_wide  = (q.widx == '0) || q.aw8;
        word_addr = (q.widx == '0) ? 8'd0
                                   : 8'(MAC_BASE) + 8'(q.widx) - 8'd1;
        cmd       = use_wide ? {OPC_READ, word_addr}
                             : {2'b00, OPC_READ, word_addr[ADDR_NARROW-1:0]};
        if (tick && !q.done) begin
            unique case (q.st)
                S_CSLO: begin
                    n.cs = 1'b1;
                    n.st = S_CSHI;
                end
                S_CSHI: begin
                    n.bitn = use_wide ? BIT_W'(CMD_W - 1)
                                      : BIT_W'(OPC_W + ADDR_NARROW - 1);
                    n.di   = cmd[n.bitn];
                    n.st   = S_CMDL;
                end
                S_CMDL: begin
                    n.sk = 1'b1;
                    n.st = S_CMDH;
                end
                S_CMDH: begin
                    n.sk = 1'b0;
                    if (q.bitn == '0) begin
                        n.di = 1'b0;
                        n.st = S_GAP;
                    end else begin
                        n.bitn = q.bitn - 1'b1;
                        n.di   = cmd[n.bitn];
                        n.st   = S_CMDL;
                    end
                end
                S_GAP: begin
                    n.sk   = 1'b1;
                    n.bitn = BIT_W'(WORD_W - 1);
                    n.st   = S_DATH;
                end
                S_DATH: begin
                    n.sh = {q.sh[WORD_W-2:0], do_in};
                    n.sk = 1'b0;
                    n.st = S_DATL;
                end
                S_DATL: begin
                    if (q.bitn == '0) begin
                        n.cs = 1'b0;
                        n.st = S_FIN;
                    end else begin
                        n.bitn = q.bitn - 1'b1;
                        n.sk   = 1'b1;
                        n.st   = S_DATH;
                    end
                end
                S_FIN: begin
                    if (q.widx == '0) n.aw8 = (q.sh == WIDE_SIG);
                    for (int k = 0; k < MAC_WORDS; k++) begin
                        if (q.widx == WIDX_W'(k + 1))
                            n.mac[k*WORD_W +: WORD_W] = q.sh;
                    end
                    if (q.widx == WIDX_W'(MAC_WORDS)) begin
                        n.done = 1'b1;
                        n.st   = S_DONE;
                    end else begin
                        n.widx = q.widx + 1'b1;
                        n.cs   = 1'b1;
                        n.st   = S_CSHI;
                    end
                end
                default: n.st = S_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_CSLO;
        end else begin
            q <= n;
        end
    end

    assign cs   = q.cs;
    assign sk   = q.sk;
    assign di   = q.di;
    assign mac  = q.mac;
    assign done = q.done;
endmodule

// File: rtl/mw_ctl_reg.sv
module mw_ctl_reg import mwl_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock,
    input  logic       wr,
    input  logic [7:1] wdata,
    input  logic       din_sync,
    output logic [7:0] rdata,
    output logic       bb_en,
    output logic       bb_cs,
    output logic       bb_sk,
    output logic       bb_di
);
    ctl_t q, n;

    always_comb begin
        n = q;
        if (wr && !lock) n.bits = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rdata = {q.bits, din_sync};
    assign bb_en = q.bits[CB_EN];
    assign bb_cs = q.bits[CB_SEL];
    assign bb_sk = q.bits[CB_CLK];
    assign bb_di = q.bits[CB_DIN];
endmodule

// File: rtl/mw_mac_loader.sv
module mw_mac_loader import mwl_pkg::*; #(
    parameter int HALF_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    output logic             ee_cs,
    output logic             ee_sk,
    output logic             ee_di,
    input  logic             ee_do,
    output logic [MAC_W-1:0] mac_addr,
    output logic             autoload_done
);
    logic [1:0] sync_d, sync_q;
    logic       tick, done;
    logic       s_cs, s_sk, s_di;
    logic       b_en, b_cs, b_sk, b_di;
    logic       unused_wr_lsb;

    assign unused_wr_lsb = ctl_wdata[CB_DOUT];

    always_comb sync_d = {sync_q[0], ee_do};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    mw_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .en(!done), .tick(tick)
    );

    mw_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .do_in(sync_q[1]),
        .cs(s_cs), .sk(s_sk), .di(s_di), .mac(mac_addr), .done(done)
    );

    mw_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .lock(!done), .wr(ctl_wr),
        .wdata(ctl_wdata[7:1]), .din_sync(sync_q[1]), .rdata(ctl_rdata),
        .bb_en(b_en), .bb_cs(b_cs), .bb_sk(b_sk), .bb_di(b_di)
    );

    always_comb begin
        if (!done) begin
            ee_cs = s_cs; ee_sk = s_sk; ee_di = s_di;
        end else if (b_en) begin
            ee_cs = b_cs; ee_sk = b_sk; ee_di = b_di;
        end else begin
            ee_cs = 1'b0; ee_sk = 1'b0; ee_di = 1'b0;
        end
    end

    assign autoload_done = done;
endmodule

// File: rtl/mw_mac_loader_chk.sv
module mw_mac_loader_chk import mwl_pkg::*; #(
    parameter int HALF_DIV = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctl_rdata,
    input logic             ee_cs,
    input logic             ee_sk,
    input logic             ee_di,
    input logic [MAC_W-1:0] mac_addr,
    input logic             autoload_done
);
    logic [15:0] run_q;
    logic        sk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= '0;
            sk_prev_q <= 1'b0;
        end else begin
            sk_prev_q <= ee_sk;
            if (ee_sk != sk_prev_q)   run_q <= 16'd1;
            else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
        end
    end

    assert_half_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!autoload_done && ee_sk != sk_prev_q) |-> run_q >= 16'(HALF_DIV));

    assert_di_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!autoload_done && ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    assert_sel_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!autoload_done && $rose(ee_cs)) |-> !ee_sk);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        autoload_done |=> autoload_done);

    assert_mac_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        autoload_done |=> $stable(mac_addr));

    assert_locked_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !autoload_done |-> ctl_rdata[7:1] == 7'd0);

    assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (autoload_done && !ctl_rdata[CB_EN]) |-> (!ee_cs && !ee_sk && !ee_di));
endmodule

bind mw_mac_loader mw_mac_loader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .ee_cs(ee_cs),
    .ee_sk(ee_sk), .ee_di(ee_di), .mac_addr(mac_addr),
    .autoload_done(autoload_done)
);

// File: tb/sim_mw_mac_loader.sv
`timescale 1ns/1ps
module sim_mw_mac_loader;
    import mwl_pkg::*;
    localparam int H = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [7:0]       ctl_wdata = '0;
    logic [7:0]       ctl_rdata;
    logic             ee_cs, ee_sk, ee_di;
    logic             ee_do = 1'b0;
    logic [MAC_W-1:0] mac_addr;
    logic             autoload_done;

    mw_mac_loader #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do), .mac_addr(mac_addr), .autoload_done(autoload_done)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] rom [0:255];
    int          m_aw = 8;
    int          m_cnt;
    logic [10:0] m_cmd;
    bit          m_started, m_reading;
    logic [15:0] m_sh;
    int          log_addr [0:15];
    int          log_n, cs_rises, sk_rises;

    always @(posedge ee_cs) begin
        m_started = 0; m_reading = 0; m_cnt = 0; m_cmd = '0;
        cs_rises++;
    end

    always @(posedge ee_sk) begin
        sk_rises++;
        if (ee_cs) begin
            if (m_reading) begin
                ee_do = m_sh[15];
                m_sh  = {m_sh[14:0], 1'b0};
            end else if (!m_started) begin
                if (ee_di) m_started = 1;
            end else begin
                m_cmd = {m_cmd[9:0], ee_di};
                m_cnt++;
                if (m_cnt == 2 + m_aw && ((int'(m_cmd) >> m_aw) & 3) == 2) begin
                    if (log_n < 16) log_addr[log_n] = int'(m_cmd) & ((1 << m_aw) - 1);
                    m_sh = rom[int'(m_cmd) & ((1 << m_aw) - 1)];
                    log_n++;
                    m_reading = 1;
                end
            end
        end
    end

    // ---------------- serial timing monitor ----------------
    bit   mon_on = 0;
    logic p_sk = 0, p_di = 0;
    int   hi_run, lo_run, hi_bad, lo_bad, di_bad;

    always @(negedge clk) begin
        if (mon_on) begin
            if (ee_sk) begin
                if (p_sk && ee_di !== p_di) di_bad++;
                hi_run++;
            end else begin
                lo_run++;
            end
            if (!ee_sk && p_sk) begin
                if (hi_run != H) hi_bad++;
                hi_run = 0;
            end
            if (ee_sk && !p_sk) begin
                if (lo_run < H) lo_bad++;
                lo_run = 0;
            end
            p_sk = ee_sk; p_di = ee_di;
        end
    end

    function automatic logic [47:0] exp_mac();
        return {rom[MAC_BASE + 2], rom[MAC_BASE + 1], rom[MAC_BASE]};
    endfunction

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic run_case(input int aw_m, input logic [15:0] w0, input bit first);
        int  cyc, wbad;
        bit  wide, good;
        logic [47:0] m0;
        m_aw = aw_m;
        for (int i = 0; i < 256; i++) rom[i] = 16'($urandom);
        rom[0] = w0;
        wide = (aw_m == 8) && (w0 == WIDE_SIG);
        good = wide || (aw_m == 6);
        rst_n = 1'b0; ctl_wr = 1'b0;
        repeat (3) @(negedge clk);
        if (first) begin
            chk("R1", "done in reset", 64'(autoload_done), 64'd0);
            chk("R1", "mac in reset", 64'(mac_addr), 64'd0);
            chk("R1", "pins in reset", 64'({ee_cs, ee_sk, ee_di}), 64'd0);
            chk("R1", "reg in reset", 64'(ctl_rdata[7:1]), 64'd0);
        end
        log_n = 0; cs_rises = 0; sk_rises = 0;
        hi_run = 0; lo_run = 0; hi_bad = 0; lo_bad = 0; di_bad = 0;
        p_sk = 0; p_di = 0; mon_on = 1;
        rst_n = 1'b1;
        cyc = 0; wbad = 0;
        while (!autoload_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (ctl_rdata[7:1] != 7'd0) wbad++;
            ctl_wr = 1'b0;
            if ($urandom % 5 == 0) begin
                ctl_wr = 1'b1;
                ctl_wdata = 8'h8E | 8'($urandom);
            end
        end
        ctl_wr = 1'b0;
        mon_on = 0;
        @(negedge clk);
        chk("R8", "done raised", 64'(autoload_done), 64'd1);
        chk("R9", "reg untouched during load", 64'(wbad), 64'd0);
        chk("R9", "reg after load", 64'(ctl_rdata[7:1]), 64'd0);
        chk("R11", "pins idle after load", 64'({ee_cs, ee_sk, ee_di}), 64'd0);
        chk("R3", "access count", 64'(cs_rises), 64'd4);
        chk("R5", "clock edges", 64'(sk_rises), wide ? 64'd108 : 64'd102);
        chk("R2", "high phase length", 64'(hi_bad), 64'd0);
        chk("R2", "low phase length", 64'(lo_bad), 64'd0);
        chk("R4", "data stable while clock high", 64'(di_bad), 64'd0);
        chk("R6", "first address", 64'(log_addr[0]), 64'd0);
        for (int k = 0; k < 3; k++)
            chk("R6", "word address", 64'(log_addr[k + 1]),
                good ? 64'(MAC_BASE + k) : 64'((MAC_BASE + k) << 2));
        if (good) begin
            chk("R7", "mac value", 64'(mac_addr), 64'(exp_mac()));
            chk("R7", "byte0 is low byte of word 7", 64'(mac_addr[7:0]), 64'(rom[MAC_BASE][7:0]));
        end
        m0 = mac_addr;
        repeat (40) @(negedge clk);
        chk("R8", "mac frozen", 64'(mac_addr), 64'(m0));
        chk("R8", "done sticky", 64'(autoload_done), 64'd1);
    endtask

    task automatic bb_read(input int addr, output logic [15:0] v);
        logic [10:0] c;
        c = {3'b110, 8'(addr)};
        wr(8'h80); wr(8'h88);
        for (int i = 10; i >= 0; i--) begin
            wr(8'h88 | {6'd0, c[i], 1'b0});
            wr(8'h8C | {6'd0, c[i], 1'b0});
        end
        wr(8'h88);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            wr(8'h8C);
            repeat (3) @(negedge clk);
            v = {v[14:0], ctl_rdata[0]};
            wr(8'h88);
        end
        wr(8'h00);
    endtask

    task automatic bitbang_tests();
        logic [15:0] v;
        logic [26:0] c;
        int pbad;
        wr(8'h0E);
        chk("R11", "disabled pins", 64'({ee_cs, ee_sk, ee_di}), 64'd0);
        chk("R12", "readback disabled", 64'(ctl_rdata[7:1]), 64'h07);
        wr(8'h8E);
        chk("R10", "enabled pins", 64'({ee_cs, ee_sk, ee_di}), 64'h7);
        chk("R12", "readback enabled", 64'(ctl_rdata[7:1]), 64'h47);
        wr(8'h8A);
        chk("R10", "clock low, select and data high", 64'({ee_cs, ee_sk, ee_di}), 64'h5);
        wr(8'h00);
        bb_read(MAC_BASE + 2, v);
        chk("R12", "software read word 9", 64'(v), 64'(rom[MAC_BASE + 2]));
        bb_read(0, v);
        chk("R12", "software read word 0", 64'(v), 64'(WIDE_SIG));
        // write (101) then erase (111) commands shifted by software
        pbad = 0;
        for (int cmdsel = 0; cmdsel < 2; cmdsel++) begin
            c = {(cmdsel == 0) ? 3'b101 : 3'b111, 8'($urandom), 16'($urandom)};
            wr(8'h88);
            for (int i = 26; i >= 0; i--) begin
                wr(8'h88 | {6'd0, c[i], 1'b0});
                if ({ee_cs, ee_sk, ee_di} !== {1'b1, 1'b0, c[i]}) pbad++;
                wr(8'h8C | {6'd0, c[i], 1'b0});
                if ({ee_cs, ee_sk, ee_di} !== {1'b1, 1'b1, c[i]}) pbad++;
            end
            wr(8'h00);
            if ({ee_cs, ee_sk, ee_di} !== 3'b000) pbad++;
        end
        chk("R10", "write and erase pass-through", 64'(pbad), 64'd0);
        chk("R8", "done after software access", 64'(autoload_done), 64'd1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        void'($urandom(32'd5813));
        run_case(8, WIDE_SIG, 1);
        bitbang_tests();
        run_case(6, 16'($urandom), 0);
        run_case(8, WIDE_SIG ^ 16'h0001, 0);
        run_case(8, WIDE_SIG ^ 16'h8000, 0);
        for (int it = 0; it < 3; it++) begin
            if ($urandom % 2 == 0) run_case(6, 16'($urandom), 0);
            else if ($urandom % 2 == 0) run_case(8, WIDE_SIG, 0);
            else run_case(8, WIDE_SIG ^ (16'd1 << ($urandom % 16)), 0);
        end
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule